// File: doc/BRIEF.md
# Fixed-Priority Multithreaded Issue Scheduler

This block is the issue stage of a small core that holds four hardware thread contexts. Each cycle every context may present one ready instruction together with a class bit that says whether it needs the simple arithmetic pipeline or the complex-operation unit. The scheduler picks at most one context per cycle and issues its instruction. The choice uses a strict priority in which context 0 is highest. There is no rotation.

Both execution paths are fully pipelined, fixed-latency models that accept an operation every cycle. A context that issues is marked busy and is skipped until its result comes back on the matching writeback port. A context waiting on a long complex result therefore never holds back the others. The complex unit is shared with other cores. The scheduler raises a request toward an external round-robin arbiter and issues the complex operation only in a cycle where the grant comes back. When the grant is refused, a lower-priority context with a simple operation may issue in its place.

A context can be retired with a finish pulse. It then stays out of selection until a reload pulse restores it.

Top module: `mt_issue_sched`

## Requirements
- R1: The issued instruction names its context on `iss_tid` (0 to 3). `iss_cpx` equals the class bit `thr_cpx` (1 = complex, 0 = simple) of that context.
- R2: A context is eligible only when its `thr_valid` bit is 1, it is not busy and it is not finished. At most one instruction issues per cycle. With no eligible context, `iss_valid` is 0.
- R3: Among eligible contexts with simple operations, the lowest index wins in every cycle, with no fairness rotation.
- R4: An issuing context stays busy until its writeback. A simple operation issued in cycle c writes back on the simple writeback port in cycle c+ALU_LAT (default 4). A complex operation writes back on the complex writeback port in cycle c+CPX_LAT (default 20). The context may issue again in its writeback cycle.
- R5: `cpx_req` is 1 exactly when the lowest-indexed eligible complex context has a lower index than every eligible simple context. A complex operation issues only in a cycle where `cpx_req` and `cpx_gnt` are both 1, and it always issues then.
- R6: When the grant is refused, the lowest eligible simple context issues that cycle. A context busy on a complex operation never stops other contexts from issuing.
- R7: Both pipelines accept a new operation every cycle, so distinct contexts can issue back to back.
- R8: A `thr_fin` pulse makes a context ineligible from the next cycle on. A later `thr_reload` pulse makes it eligible again. Reload wins if both pulses arrive together.
- R9: After reset, no context is busy or finished and neither writeback port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_valid | input | NTHR | Context has a ready instruction |
| thr_cpx | input | NTHR | Operation class per context, 1 = complex |
| thr_fin | input | NTHR | Pulse: context finished |
| thr_reload | input | NTHR | Pulse: context reloaded |
| cpx_gnt | input | 1 | Grant from the shared complex-unit arbiter, same cycle |
| cpx_req | output | 1 | Request to the shared complex-unit arbiter |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_cpx | output | 1 | The issued instruction is complex |
| iss_tid | output | TW | Issuing context |
| alu_wb_valid | output | 1 | Simple-pipeline writeback |
| alu_wb_tid | output | TW | Context of the simple writeback |
| cpx_wb_valid | output | 1 | Complex-unit writeback |
| cpx_wb_tid | output | TW | Context of the complex writeback |

## Verification
The properties assume that the external arbiter answers in the same cycle and grants only while a request is raised. The bench drives `cpx_gnt` as a free input, and every check depends only on cycles where the request is high. The checker keeps its own busy and finished map, built only from the issue, writeback, finish and reload ports. It takes for granted that finish and reload arrive as single-cycle pulses. The bench produces them that way, with all inputs changed half a period away from the active edge.

// File: rtl/mt_issue_sched.sv
module mt_issue_sched #(
  parameter int NTHR    = 4,
  parameter int ALU_LAT = 4,
  parameter int CPX_LAT = 20,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_valid,
  input  logic [NTHR-1:0] thr_cpx,
  input  logic [NTHR-1:0] thr_fin,
  input  logic [NTHR-1:0] thr_reload,
  input  logic            cpx_gnt,
  output logic            cpx_req,
  output logic            iss_valid,
  output logic            iss_cpx,
  output logic [TW-1:0]   iss_tid,
  output logic            alu_wb_valid,
  output logic [TW-1:0]   alu_wb_tid,
  output logic            cpx_wb_valid,
  output logic [TW-1:0]   cpx_wb_tid
);

  logic [NTHR-1:0] busy, done, wb_clr, elig, iss_mask;
  logic [ALU_LAT-1:0] alu_v;
  logic [TW-1:0]      alu_t [ALU_LAT];
  logic [CPX_LAT-1:0] cpx_v;
  logic [TW-1:0]      cpx_t [CPX_LAT];
  logic            s_hit, c_hit, take_cpx;
  logic [TW-1:0]   s_idx, c_idx;

  assign alu_wb_valid = alu_v[ALU_LAT-1];
  assign alu_wb_tid   = alu_t[ALU_LAT-1];
  assign cpx_wb_valid = cpx_v[CPX_LAT-1];
  assign cpx_wb_tid   = cpx_t[CPX_LAT-1];

  always_comb begin
    wb_clr = '0;
    if (alu_wb_valid) wb_clr[alu_wb_tid] = 1'b1;
    if (cpx_wb_valid) wb_clr[cpx_wb_tid] = 1'b1;
  end

  assign elig = thr_valid & ~done & ~(busy & ~wb_clr);

  always_comb begin
    s_hit = 1'b0; s_idx = '0;
    c_hit = 1'b0; c_idx = '0;
    for (int i = NTHR-1; i >= 0; i--) begin
      if (elig[i] && !thr_cpx[i]) begin s_hit = 1'b1; s_idx = TW'(i); end
      if (elig[i] &&  thr_cpx[i]) begin c_hit = 1'b1; c_idx = TW'(i); end
    end
  end

  assign cpx_req   = c_hit && (!s_hit || c_idx < s_idx);
  assign take_cpx  = cpx_req && cpx_gnt;
  assign iss_valid = take_cpx || s_hit;
  assign iss_cpx   = take_cpx;
  assign iss_tid   = take_cpx ? c_idx : s_idx;

  always_comb begin
    iss_mask = '0;
    if (iss_valid) iss_mask[iss_tid] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      done  <= '0;
      alu_v <= '0;
      cpx_v <= '0;
      for (int k = 0; k < ALU_LAT; k++) alu_t[k] <= '0;
      for (int k = 0; k < CPX_LAT; k++) cpx_t[k] <= '0;
    end else begin
      busy  <= (busy & ~wb_clr) | iss_mask;
      done  <= (done | thr_fin) & ~thr_reload;
      alu_v <= {alu_v[ALU_LAT-2:0], iss_valid && !iss_cpx};
      cpx_v <= {cpx_v[CPX_LAT-2:0], take_cpx};
      alu_t[0] <= iss_tid;
      cpx_t[0] <= iss_tid;
      for (int k = 1; k < ALU_LAT; k++) alu_t[k] <= alu_t[k-1];
      for (int k = 1; k < CPX_LAT; k++) cpx_t[k] <= cpx_t[k-1];
    end
  end

endmodule

// File: rtl/mt_issue_sched_chk.sv
module mt_issue_sched_chk #(
  parameter int NTHR    = 4,
  parameter int ALU_LAT = 4,
  parameter int CPX_LAT = 20,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] thr_valid,
  input logic [NTHR-1:0] thr_cpx,
  input logic [NTHR-1:0] thr_fin,
  input logic [NTHR-1:0] thr_reload,
  input logic            cpx_gnt,
  input logic            cpx_req,
  input logic            iss_valid,
  input logic            iss_cpx,
  input logic [TW-1:0]   iss_tid,
  input logic            alu_wb_valid,
  input logic [TW-1:0]   alu_wb_tid,
  input logic            cpx_wb_valid,
  input logic [TW-1:0]   cpx_wb_tid
);

  logic [NTHR-1:0] sh_busy, sh_done, sh_wb;

  always_comb begin
    sh_wb = '0;
    if (alu_wb_valid) sh_wb[alu_wb_tid] = 1'b1;
    if (cpx_wb_valid) sh_wb[cpx_wb_tid] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_busy <= '0;
      sh_done <= '0;
    end else begin
      sh_busy <= sh_busy & ~sh_wb;
      if (iss_valid) sh_busy[iss_tid] <= 1'b1;
      sh_done <= (sh_done | thr_fin) & ~thr_reload;
    end
  end

  a_r1_class_match: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_cpx == thr_cpx[iss_tid]);

  a_r2_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> thr_valid[iss_tid]);

  a_r4_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (!sh_busy[iss_tid] || sh_wb[iss_tid]));

  a_r5_cpx_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cpx) |-> (cpx_req && cpx_gnt));

  a_r5_grant_used: assert property (@(posedge clk) disable iff (!rst_n)
    (cpx_req && cpx_gnt) |-> (iss_valid && iss_cpx));

  a_r7_wb_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_wb_valid && cpx_wb_valid) |-> alu_wb_tid != cpx_wb_tid);

  a_r8_finished_idle: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !sh_done[iss_tid]);

  a_r9_wb_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!alu_wb_valid && !cpx_wb_valid));

endmodule

bind mt_issue_sched mt_issue_sched_chk #(
  .NTHR(NTHR), .ALU_LAT(ALU_LAT), .CPX_LAT(CPX_LAT)
) u_chk (.*);

// File: tb/mt_issue_sched_bench.sv
`timescale 1ns/1ps
module mt_issue_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] thr_valid, thr_cpx, thr_fin, thr_reload;
  logic       cpx_gnt, cpx_req, iss_valid, iss_cpx;
  logic [1:0] iss_tid, alu_wb_tid, cpx_wb_tid;
  logic       alu_wb_valid, cpx_wb_valid;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mt_issue_sched u_mt_issue_sched (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_iss(input string req, input bit v, input bit c, input int tid);
    chk(iss_valid == v, {req, " iss_valid"}, iss_valid, v);
    if (v) begin
      chk(iss_cpx == c, {req, " iss_cpx"}, iss_cpx, c);
      chk(iss_tid == tid, {req, " iss_tid"}, iss_tid, tid);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    thr_valid = '0; thr_cpx = '0; thr_fin = '0; thr_reload = '0; cpx_gnt = 1'b0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    expect_iss("R9", 1'b0, 1'b0, 0);
    chk(cpx_req == 1'b0, "R9 cpx_req", cpx_req, 0);
    chk(alu_wb_valid == 1'b0, "R9 alu_wb", alu_wb_valid, 0);
    chk(cpx_wb_valid == 1'b0, "R9 cpx_wb", cpx_wb_valid, 0);
    thr_valid = 4'hF; #1;
    expect_iss("R2 all ready after reset", 1'b1, 1'b0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    thr_valid = 4'hF; thr_cpx = 4'h0; #1;
    expect_iss("R3 first", 1'b1, 1'b0, 0);
    for (int k = 1; k < 4; k++) begin
      tick(); #1;
      expect_iss("R7 back-to-back", 1'b1, 1'b0, k);
      chk(alu_wb_valid == 1'b0, "R4 no early wb", alu_wb_valid, 0);
    end
    tick(); #1;
    chk(alu_wb_valid && alu_wb_tid == 0, "R4 alu wb latency", alu_wb_tid, 0);
    expect_iss("R4 reissue in wb cycle", 1'b1, 1'b0, 0);
    tick(); #1;
    chk(alu_wb_valid && alu_wb_tid == 1, "R4 alu wb next", alu_wb_tid, 1);
    expect_iss("R3 slot1 after wb", 1'b1, 1'b0, 1);
    thr_valid = 4'h0;
  endtask

  task automatic t_complex_stall();
    do_reset();
    thr_valid = 4'b0011; thr_cpx = 4'b0001; cpx_gnt = 1'b1; #1;
    chk(cpx_req == 1'b1, "R5 req", cpx_req, 1);
    expect_iss("R5 complex issue", 1'b1, 1'b1, 0);
    tick(); cpx_gnt = 1'b0; #1;
    chk(cpx_req == 1'b0, "R5 busy ctx no req", cpx_req, 0);
    expect_iss("R6 stall not blocking", 1'b1, 1'b0, 1);
    tick(); thr_valid = 4'b0001; #1;
    for (int k = 2; k < 20; k++) begin
      chk(cpx_wb_valid == 1'b0, "R4 no early cpx wb", cpx_wb_valid, 0);
      tick(); #1;
    end
    cpx_gnt = 1'b1; #1;
    chk(cpx_wb_valid && cpx_wb_tid == 0, "R4 cpx wb latency", cpx_wb_valid, 1);
    expect_iss("R4 cpx reissue in wb cycle", 1'b1, 1'b1, 0);
    thr_valid = 4'h0; cpx_gnt = 1'b0;
  endtask

  task automatic t_denied();
    do_reset();
    thr_valid = 4'b0011; thr_cpx = 4'b0001; cpx_gnt = 1'b0; #1;
    chk(cpx_req == 1'b1, "R5 req when denied", cpx_req, 1);
    expect_iss("R6 denied falls to simple", 1'b1, 1'b0, 1);
    tick(); thr_valid = 4'b0001; #1;
    chk(cpx_req == 1'b1, "R5 req held", cpx_req, 1);
    expect_iss("R5 no grant no issue", 1'b0, 1'b0, 0);
    cpx_gnt = 1'b1; #1;
    expect_iss("R5 grant issues", 1'b1, 1'b1, 0);
    thr_valid = 4'h0; cpx_gnt = 1'b0;
  endtask

  task automatic t_suppressed();
    do_reset();
    thr_valid = 4'b0011; thr_cpx = 4'b0010; cpx_gnt = 1'b1; #1;
    chk(cpx_req == 1'b0, "R5 higher simple suppresses req", cpx_req, 0);
    expect_iss("R3 simple slot0 first", 1'b1, 1'b0, 0);
    tick(); #1;
    chk(cpx_req == 1'b1, "R5 req after slot0 busy", cpx_req, 1);
    expect_iss("R1 complex slot1", 1'b1, 1'b1, 1);
    thr_valid = 4'h0; cpx_gnt = 1'b0;
  endtask

  task automatic t_done();
    do_reset();
    thr_fin = 4'b0001;
    tick(); thr_fin = 4'b0000; thr_valid = 4'b0011; #1;
    expect_iss("R8 finished skipped", 1'b1, 1'b0, 1);
    tick(); thr_valid = 4'b0001; #1;
    expect_iss("R8 finished stays idle", 1'b0, 1'b0, 0);
    thr_fin = 4'b0001; thr_reload = 4'b0001;
    tick(); thr_fin = 4'b0000; thr_reload = 4'b0000; #1;
    expect_iss("R8 reload wins and restores", 1'b1, 1'b0, 0);
    thr_valid = 4'h0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_priority();
    t_complex_stall();
    t_denied();
    t_suppressed();
    t_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule